// File: doc/BRIEF.md
# Two-Channel DMA Interrupt Cause Collector

This block gathers completion and fault events from a pair of DMA channels into a single shared cause word and a shared enable word. Each channel owns one 16-bit half of each word. Channel 0 uses the low half and channel 1 uses the high half. Incoming one-cycle event pulses set sticky cause bits. The block drives one level-sensitive interrupt line per channel. That line stays high while any enabled cause in the channel's half is pending.

Software clears causes by writing zeros. A 1 written to a cause bit leaves it alone. A channel's handler can therefore clear its own bits without reading the word first, and without disturbing the other channel. The block also latches diagnostic data for each channel when the first fault arrives: the set of fault kinds that arrived together, and the faulting address. That snapshot is held until every fault cause of the channel has been cleared.

The registers sit on a plain single-cycle bus. A write takes effect at the clock edge. Read data is combinational from the registers.

Top module: `chan_irq_cause`

## Requirements
- R1: After reset every register reads zero and both interrupt outputs are low.
- R2: A pulse on `eoc_evt[n]` sets cause bit 16n. A pulse on `err_evt[6n+k]` (k = 0..5) sets cause bit 16n+4+k. The bit is visible from the cycle after the pulse and stays set until software clears it.
- R3: A write to word 0 (cause) clears every cause bit written as 0 and leaves every bit written as 1 unchanged. No cause bit is cleared without such a write.
- R4: Writing 0xFFFF0000 clears all of channel 0's causes, and writing 0x0000FFFF clears all of channel 1's causes. In both cases the other channel's causes are untouched.
- R5: When a cause event and a clearing write of the same bit fall in the same cycle, the bit remains set.
- R6: Word 1 (mask) is read/write with the same layout as the cause word. `irq[n]` is high exactly when some bit of channel n's cause half is set together with its mask bit.
- R7: Only bits 0 and 4..9 of each half can ever be set in the cause word. The other bits always read 0, including after a write of all ones.
- R8: Word 2 (fault kinds, read-only) holds in bits [16n+5:16n] the fault kinds captured for channel n. Word 3+n (read-only) holds channel n's captured fault address. Writes to words 2 and 3+n have no effect.
- R9: Capture happens only when a fault pulse arrives while channel n has no fault cause (bits 4..9) pending. While any fault cause is pending, later faults do not change the captured kinds or address. Completion events never trigger a capture.
- R10: Words 5 to 7 read as zero, and writing them changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eoc_evt | input | 2 | Per-channel end-of-chain event pulse |
| err_evt | input | 12 | Fault-kind pulses, six per channel (channel n at [6n+5:6n]) |
| fault_addr | input | 64 | Faulting address per channel (channel n at [32n+31:32n]) |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 2 | Per-channel level interrupt |

## Verification
Each cause bit, mask bit and capture register has a single register stage between its input and its output. A pulse or a write applied in one cycle is therefore visible on `bus_rdata` and `irq` from the next cycle on. Read data and the interrupt lines involve no extra delay beyond those registers. The bench changes inputs on the falling edge and holds them for exactly one rising edge. It then samples reads on the following falling edge, after the edge that updated the state. The collision case, the capture lock and its re-arm are each checked in the first cycle in which their effect is due.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;
  localparam int FIELD_W    = 16;
  localparam int ERR_KINDS  = 6;
  localparam int ERR_LO     = 4;
  localparam int CAUSE_IDX  = 0;
  localparam int MASK_IDX   = 1;
  localparam int KINDS_IDX  = 2;
  localparam int EADDR_BASE = 3;
  localparam logic [FIELD_W-1:0] FIELD_VALID = 16'h03F1;

  // place one channel's event pulses at their cause-bit positions
  function automatic logic [FIELD_W-1:0] pack_events(input logic eoc,
                                                     input logic [ERR_KINDS-1:0] err);
    logic [FIELD_W-1:0] v;
    v = '0;
    v[0] = eoc;
    v[ERR_LO +: ERR_KINDS] = err;
    return v;
  endfunction

  // write-zero-to-clear, then set by events (events win)
  function automatic logic [FIELD_W-1:0] field_next(input logic [FIELD_W-1:0] cur,
                                                    input logic clr_en,
                                                    input logic [FIELD_W-1:0] wfield,
                                                    input logic [FIELD_W-1:0] evts);
    logic [FIELD_W-1:0] kept;
    kept = clr_en ? (cur & wfield) : cur;
    return (kept | evts) & FIELD_VALID;
  endfunction

  function automatic logic fault_pending(input logic [FIELD_W-1:0] cur);
    return |cur[ERR_LO +: ERR_KINDS];
  endfunction
endpackage

// File: rtl/chan_irq_field.sv
module chan_irq_field
  import chan_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_en,
  input  logic [FIELD_W-1:0]   wfield,
  input  logic [FIELD_W-1:0]   mask_field,
  input  logic                 eoc,
  input  logic [ERR_KINDS-1:0] err,
  output logic [FIELD_W-1:0]   cause_q,
  output logic                 irq,
  output logic                 err_active
);
  logic [FIELD_W-1:0] evts;

  assign evts = pack_events(eoc, err);

  always_ff @(posedge clk) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= field_next(cause_q, clr_en, wfield, evts);
  end

  assign irq        = |(cause_q & mask_field);
  assign err_active = fault_pending(cause_q);
endmodule

// File: rtl/chan_irq_errcap.sv
module chan_irq_errcap
  import chan_irq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 err_active,
  input  logic [ERR_KINDS-1:0] err,
  input  logic [AW-1:0]        addr_in,
  output logic [ERR_KINDS-1:0] kinds_q,
  output logic [AW-1:0]        addr_q,
  output logic                 capture
);
  // first fault only: lock while any fault cause is pending
  assign capture = !err_active && (|err);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kinds_q <= '0;
      addr_q  <= '0;
    end else if (capture) begin
      kinds_q <= err;
      addr_q  <= addr_in;
    end
  end
endmodule

// File: rtl/chan_irq_regs.sv
module chan_irq_regs
  import chan_irq_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int REG_AW = 3,
  parameter int AW     = 32,
  localparam int DATA_W = NUM_CH * FIELD_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_we,
  input  logic [REG_AW-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  input  logic [DATA_W-1:0]      cause_word,
  input  logic [DATA_W-1:0]      kinds_word,
  input  logic [NUM_CH*AW-1:0]   eaddr_flat,
  output logic [DATA_W-1:0]      mask_q,
  output logic                   cause_wr,
  output logic [DATA_W-1:0]      bus_rdata
);
  logic mask_wr;

  assign cause_wr = bus_we && (bus_addr == REG_AW'(CAUSE_IDX));
  assign mask_wr  = bus_we && (bus_addr == REG_AW'(MASK_IDX));

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= bus_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == REG_AW'(CAUSE_IDX)) bus_rdata = cause_word;
    if (bus_addr == REG_AW'(MASK_IDX))  bus_rdata = mask_q;
    if (bus_addr == REG_AW'(KINDS_IDX)) bus_rdata = kinds_word;
    for (int n = 0; n < NUM_CH; n++) begin
      if (bus_addr == REG_AW'(EADDR_BASE + n))
        bus_rdata = DATA_W'(eaddr_flat[n*AW +: AW]);
    end
  end
endmodule

// File: rtl/chan_irq_cause.sv
module chan_irq_cause
  import chan_irq_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int REG_AW = 3,
  parameter int AW     = 32,
  localparam int DATA_W = NUM_CH * FIELD_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CH-1:0]           eoc_evt,
  input  logic [NUM_CH*ERR_KINDS-1:0] err_evt,
  input  logic [NUM_CH*AW-1:0]        fault_addr,
  input  logic                        bus_we,
  input  logic [REG_AW-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  output logic [NUM_CH-1:0]           irq
);
  logic [DATA_W-1:0]    cause_q;
  logic [DATA_W-1:0]    mask_q;
  logic [DATA_W-1:0]    kinds_word;
  logic [NUM_CH*AW-1:0] eaddr_flat;
  logic [NUM_CH-1:0]    err_active;
  logic [NUM_CH-1:0]    capture;
  logic                 cause_wr;

  chan_irq_regs #(.NUM_CH(NUM_CH), .REG_AW(REG_AW), .AW(AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .cause_word (cause_q),
    .kinds_word (kinds_word),
    .eaddr_flat (eaddr_flat),
    .mask_q     (mask_q),
    .cause_wr   (cause_wr),
    .bus_rdata  (bus_rdata)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic [ERR_KINDS-1:0] kinds_q;

    chan_irq_field u_field (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_en     (cause_wr),
      .wfield     (bus_wdata[n*FIELD_W +: FIELD_W]),
      .mask_field (mask_q[n*FIELD_W +: FIELD_W]),
      .eoc        (eoc_evt[n]),
      .err        (err_evt[n*ERR_KINDS +: ERR_KINDS]),
      .cause_q    (cause_q[n*FIELD_W +: FIELD_W]),
      .irq        (irq[n]),
      .err_active (err_active[n])
    );

    chan_irq_errcap #(.AW(AW)) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .err_active (err_active[n]),
      .err        (err_evt[n*ERR_KINDS +: ERR_KINDS]),
      .addr_in    (fault_addr[n*AW +: AW]),
      .kinds_q    (kinds_q),
      .addr_q     (eaddr_flat[n*AW +: AW]),
      .capture    (capture[n])
    );

    assign kinds_word[n*FIELD_W +: FIELD_W] = FIELD_W'(kinds_q);
  end
endmodule

// File: rtl/chan_irq_chk.sv
module chan_irq_chk
  import chan_irq_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int REG_AW = 3,
  parameter int AW     = 32,
  localparam int DATA_W = NUM_CH * FIELD_W
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_CH-1:0]           eoc_evt,
  input logic [NUM_CH*ERR_KINDS-1:0] err_evt,
  input logic                        bus_we,
  input logic [REG_AW-1:0]           bus_addr,
  input logic [DATA_W-1:0]           cause_q,
  input logic [DATA_W-1:0]           mask_q,
  input logic [DATA_W-1:0]           kinds_word,
  input logic [NUM_CH*AW-1:0]        eaddr_flat,
  input logic [NUM_CH-1:0]           err_active,
  input logic [NUM_CH-1:0]           irq
);
  logic [DATA_W-1:0] evt_word;
  logic              cause_write;

  always_comb begin
    evt_word = '0;
    for (int n = 0; n < NUM_CH; n++)
      evt_word[n*FIELD_W +: FIELD_W] = pack_events(eoc_evt[n], err_evt[n*ERR_KINDS +: ERR_KINDS]);
  end
  assign cause_write = bus_we && (bus_addr == REG_AW'(CAUSE_IDX));

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_word) |=> ((cause_q & $past(evt_word)) == $past(evt_word))); // R2 R5

  AST_NO_SILENT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_write |=> ((cause_q & $past(cause_q)) == $past(cause_q))); // R3

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q & ~{NUM_CH{FIELD_VALID}}) == '0); // R7

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> (irq == '0)); // R6

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    AST_LOCK_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      err_active[n] |=> $stable(eaddr_flat[n*AW +: AW])); // R9

    AST_FIRST_FAULT_KINDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!err_active[n] && (|err_evt[n*ERR_KINDS +: ERR_KINDS])) |=>
      (kinds_word[n*FIELD_W +: ERR_KINDS] == $past(err_evt[n*ERR_KINDS +: ERR_KINDS]))); // R8
  end
endmodule

bind chan_irq_cause chan_irq_chk #(.NUM_CH(NUM_CH), .REG_AW(REG_AW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .eoc_evt    (eoc_evt),
  .err_evt    (err_evt),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .cause_q    (cause_q),
  .mask_q     (mask_q),
  .kinds_word (kinds_word),
  .eaddr_flat (eaddr_flat),
  .err_active (err_active),
  .irq        (irq)
);

// File: tb/chan_irq_cause_tb.sv
module chan_irq_cause_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  eoc_evt = '0;
  logic [11:0] err_evt = '0;
  logic [63:0] fault_addr = '0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  chan_irq_cause u_dut (
    .clk(clk), .rst_n(rst_n), .eoc_evt(eoc_evt), .err_evt(err_evt),
    .fault_addr(fault_addr), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check_rd(input logic [2:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_addr = a;
    #1;
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s word %0d got %08h exp %08h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic check_irq(input logic [1:0] exp, input string req);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq got %b exp %b", req, irq, exp);
    end
  endtask

  // one-cycle stimulus: events and an optional bus write in the same cycle
  task automatic cycle(input logic [1:0] eoc, input logic [11:0] err,
                       input logic [31:0] a0, input logic [31:0] a1,
                       input logic we, input logic [2:0] wa, input logic [31:0] wd);
    @(negedge clk);
    eoc_evt = eoc; err_evt = err; fault_addr = {a1, a0};
    bus_we = we; bus_addr = wa; bus_wdata = wd;
    @(negedge clk);
    eoc_evt = '0; err_evt = '0; bus_we = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cycle(2'b00, 12'h0, 32'h0, 32'h0, 1'b1, a, d);
  endtask

  task automatic t_reset;
    check_rd(3'd0, 32'h0, "R1");
    check_rd(3'd1, 32'h0, "R1");
    check_rd(3'd2, 32'h0, "R1");
    check_rd(3'd3, 32'h0, "R1");
    check_rd(3'd4, 32'h0, "R1");
    check_irq(2'b00, "R1");
  endtask

  task automatic t_eoc_and_mask;
    cycle(2'b01, 12'h0, 0, 0, 1'b0, 3'd0, 0);
    check_rd(3'd0, 32'h0000_0001, "R2");
    cycle(2'b10, 12'h0, 0, 0, 1'b0, 3'd0, 0);
    check_rd(3'd0, 32'h0001_0001, "R2");
    check_irq(2'b00, "R6 masked");
    wr(3'd1, 32'h0000_0001);
    check_irq(2'b01, "R6");
    check_rd(3'd1, 32'h0000_0001, "R6");
    wr(3'd1, 32'h0001_0000);
    check_irq(2'b10, "R6");
    wr(3'd1, 32'h0001_0001);
    check_irq(2'b11, "R6");
  endtask

  task automatic t_selective_clear;
    wr(3'd0, 32'hFFFF_FFFE);
    check_rd(3'd0, 32'h0001_0000, "R3");
    check_irq(2'b10, "R3");
  endtask

  task automatic t_fault_capture;
    // channel 0 kind 2 -> cause bit 6; mask enables only bit 0 of the half
    cycle(2'b00, 12'h004, 32'hA000_0040, 0, 1'b0, 3'd0, 0);
    check_rd(3'd0, 32'h0001_0040, "R2");
    check_rd(3'd2, 32'h0000_0004, "R8");
    check_rd(3'd3, 32'hA000_0040, "R8");
    check_irq(2'b10, "R6 unmasked bit only");
    // second fault while locked
    cycle(2'b00, 12'h001, 32'hB000_0000, 0, 1'b0, 3'd0, 0);
    check_rd(3'd0, 32'h0001_0050, "R2");
    check_rd(3'd2, 32'h0000_0004, "R9");
    check_rd(3'd3, 32'hA000_0040, "R9");
  endtask

  task automatic t_channel_clear;
    wr(3'd0, 32'h0000_FFFF);
    check_rd(3'd0, 32'h0000_0050, "R4 ch1");
    check_irq(2'b00, "R4");
    wr(3'd0, 32'hFFFF_0000);
    check_rd(3'd0, 32'h0000_0000, "R4 ch0");
  endtask

  task automatic t_rearm;
    cycle(2'b00, 12'h020, 32'hC000_00C0, 0, 1'b0, 3'd0, 0);
    check_rd(3'd0, 32'h0000_0200, "R2");
    check_rd(3'd2, 32'h0000_0020, "R9 rearm");
    check_rd(3'd3, 32'hC000_00C0, "R9 rearm");
    cycle(2'b00, 12'h080, 0, 32'hD000_0010, 1'b0, 3'd0, 0);
    check_rd(3'd0, 32'h0020_0200, "R2 ch1");
    check_rd(3'd2, 32'h0002_0020, "R8 ch1");
    check_rd(3'd4, 32'hD000_0010, "R8 ch1");
  endtask

  task automatic t_collision;
    cycle(2'b01, 12'h0, 0, 0, 1'b0, 3'd0, 0);
    check_rd(3'd0, 32'h0020_0201, "R2");
    check_rd(3'd2, 32'h0002_0020, "R9 eoc no capture");
    // clear bits 0 and 9 while bit 0 fires again
    cycle(2'b01, 12'h0, 0, 0, 1'b1, 3'd0, 32'hFFFF_FDFE);
    check_rd(3'd0, 32'h0020_0001, "R5");
    check_irq(2'b01, "R5");
  endtask

  task automatic t_readonly;
    wr(3'd0, 32'hFFFF_FFFF);
    check_rd(3'd0, 32'h0020_0001, "R7");
    wr(3'd2, 32'h0);
    check_rd(3'd2, 32'h0002_0020, "R8 ro");
    wr(3'd3, 32'h0);
    check_rd(3'd3, 32'hC000_00C0, "R8 ro");
  endtask

  task automatic t_unmapped;
    wr(3'd7, 32'h0);
    wr(3'd5, 32'h0);
    check_rd(3'd5, 32'h0, "R10");
    check_rd(3'd6, 32'h0, "R10");
    check_rd(3'd7, 32'h0, "R10");
    check_rd(3'd1, 32'h0001_0001, "R10 mask kept");
    check_rd(3'd0, 32'h0020_0001, "R10 cause kept");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_eoc_and_mask;
    t_selective_clear;
    t_fault_capture;
    t_channel_clear;
    t_rearm;
    t_collision;
    t_readonly;
    t_unmapped;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule